// File: doc/BRIEF.md
# One-Shot / Periodic Countdown Timer with Level Interrupt

This block is a programmable down-counter advanced by a one-microsecond tick strobe that arrives on an input port. Software arms it with a single write to the trigger register. That word carries an enable bit, a periodic-mode bit and a reload count. The count register reads back the running value and also acknowledges the interrupt. To get an event every K ticks, software programs K-1. In one-shot mode the timer raises its interrupt once and stops. In periodic mode it reloads itself and keeps raising the interrupt every K ticks.

The interrupt output is a level and stays high until software acknowledges it. The acknowledge is a write of 1 to the clear bit of the count register. The control path is a three-state machine. **IDLE** means stopped. **ONESHOT** counts down and returns to IDLE on expiry. **PERIODIC** counts down and reloads on expiry.

The transitions are:
- arm-oneshot (any state to ONESHOT): trigger write with enable=1 and periodic=0.
- arm-periodic (any state to PERIODIC): trigger write with enable=1 and periodic=1.
- stop (any state to IDLE): trigger write with enable=0.
- oneshot-expire (ONESHOT to IDLE): a tick while the count is 0.
- periodic-expire (PERIODIC to PERIODIC, with reload): a tick while the count is 0.

Top module: `tmr_countdown`

## Requirements
- R1: After reset the interrupt is low, and both registers read as 0.
- R2: A write to the trigger register (offset 0x0) sets three fields: enable in bit 31, periodic in bit 30, and the reload count in bits [28:0]. The write loads the running count with the reload value. Reading offset 0x0 returns enable in bit 31, the periodic bit (only while enabled) in bit 30, and the reload in [28:0], with other bits 0.
- R3: While enabled, each tick lowers the count by one. Cycles without a tick leave the count and state unchanged.
- R4: With reload N, the interrupt becomes pending on the (N+1)th tick after arming.
- R5: In one-shot mode, expiry clears the enable bit, and the count stays at 0 under further ticks.
- R6: In periodic mode, expiry reloads the count and the timer keeps running, so events recur every N+1 ticks.
- R7: Writing 0 to the trigger register stops the timer. After that, ticks raise no interrupt.
- R8: A trigger write while the timer is running restarts the count from the new value.
- R9: Reading the count register (offset 0x4) returns the running count in [28:0] and the pending flag in bit 30, with other bits 0.
- R10: Writing to offset 0x4 with bit 30 set clears the pending interrupt. Such a write with bit 30 clear has no effect.
- R11: When an expiry and a clear write fall in the same cycle, the interrupt stays pending.
- R12: The interrupt output is a high level that equals the pending flag and holds until cleared.
- R13: A trigger write in the same cycle as a tick takes precedence, and that tick is not counted. Reload 0 gives an event on the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count strobe (1 MHz rate) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level-high interrupt |

## Verification
The count is driven with three tick patterns: a tick on every cycle, a tick on every third cycle, and ticks with random gaps. Under all three, expiry must follow the number of ticks rather than the number of clock cycles. Directed sequences then set events that normally happen apart into the same cycle:
- a trigger write on the same edge as a tick, which separates write priority from counting;
- a clear on the same edge as an expiry, which separates pending priority from acknowledge;
- reload 0, which checks the off-by-one rule at its smallest case.

A long random mix of arming, stopping and acknowledging is compared cycle by cycle against a behavioural model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // Bit positions decoded by software; fixed by the register layout.
    localparam int EN_BIT   = 31;
    localparam int PER_BIT  = 30;
    localparam int ACK_BIT  = 30;
    localparam int PEND_BIT = 30;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ONESHOT  = 2'd1,
        ST_PERIODIC = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int CNT_W    = 29,
    parameter int OFS_TRIG = 0,
    parameter int OFS_STAT = 4
) (
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  tmr_state_e        cur_state,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic [CNT_W-1:0]  cur_reload,
    input  logic              pend,
    output logic              trig_wr,
    output logic              ack_wr,
    output logic              new_en,
    output logic              new_per,
    output logic [CNT_W-1:0]  new_reload,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic sel_trig, sel_stat;
    logic unused_wbits;

    assign sel_trig   = (reg_addr == A_TRIG);
    assign sel_stat   = (reg_addr == A_STAT);
    assign trig_wr    = reg_we && sel_trig;
    assign ack_wr     = reg_we && sel_stat && reg_wdata[ACK_BIT];
    assign new_en     = reg_wdata[EN_BIT];
    assign new_per    = reg_wdata[PER_BIT];
    assign new_reload = reg_wdata[CNT_W-1:0];

    generate
        if (CNT_W < PER_BIT) begin : g_gap
            assign unused_wbits = ^reg_wdata[PER_BIT-1:CNT_W];
        end else begin : g_nogap
            assign unused_wbits = 1'b0;
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (sel_trig) begin
            reg_rdata[EN_BIT]      = (cur_state != ST_IDLE);
            reg_rdata[PER_BIT]     = (cur_state == ST_PERIODIC);
            reg_rdata[CNT_W-1:0]   = cur_reload;
        end else if (sel_stat) begin
            reg_rdata[PEND_BIT]    = pend;
            reg_rdata[CNT_W-1:0]   = cur_count;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig_wr,
    input  logic             new_en,
    input  logic             new_per,
    input  logic [CNT_W-1:0] new_reload,
    output tmr_state_e       cur_state,
    output logic [CNT_W-1:0] cur_count,
    output logic [CNT_W-1:0] cur_reload,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] reload_q, reload_d;
    logic             at_zero;

    assign at_zero = (count_q == '0);

    // next-state and datapath
    always_comb begin
        state_d  = state_q;
        count_d  = count_q;
        reload_d = reload_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_IDLE;
            end
            ST_ONESHOT: begin
                if (tick) begin
                    if (at_zero) state_d = ST_IDLE;       // oneshot-expire
                    else         count_d = count_q - ONE;
                end
            end
            ST_PERIODIC: begin
                if (tick) begin
                    if (at_zero) count_d = reload_q;      // periodic-expire
                    else         count_d = count_q - ONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (trig_wr) begin
            reload_d = new_reload;
            count_d  = new_reload;
            if (!new_en)      state_d = ST_IDLE;          // stop
            else if (new_per) state_d = ST_PERIODIC;      // arm-periodic
            else              state_d = ST_ONESHOT;       // arm-oneshot
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            state_q  <= state_d;
            count_q  <= count_d;
            reload_q <= reload_d;
        end
    end

    // outputs
    always_comb begin
        cur_state  = state_q;
        cur_count  = count_q;
        cur_reload = reload_q;
        expire     = tick && !trig_wr && at_zero && (state_q != ST_IDLE);
    end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack_wr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (expire) pend <= 1'b1;   // expiry beats acknowledge
        else if (ack_wr) pend <= 1'b0;
    end
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int CNT_W    = 29,
    parameter int OFS_TRIG = 0,
    parameter int OFS_STAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    tmr_state_e       cur_state;
    logic [CNT_W-1:0] cur_count, cur_reload, new_reload;
    logic             trig_wr, ack_wr, new_en, new_per, expire, pend;

    tmr_regif #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .OFS_TRIG(OFS_TRIG), .OFS_STAT(OFS_STAT)
    ) u_regif (
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cur_state(cur_state), .cur_count(cur_count), .cur_reload(cur_reload),
        .pend(pend), .trig_wr(trig_wr), .ack_wr(ack_wr), .new_en(new_en),
        .new_per(new_per), .new_reload(new_reload), .reg_rdata(reg_rdata)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig_wr(trig_wr),
        .new_en(new_en), .new_per(new_per), .new_reload(new_reload),
        .cur_state(cur_state), .cur_count(cur_count),
        .cur_reload(cur_reload), .expire(expire)
    );

    tmr_irq u_irq (
        .clk(clk), .rst_n(rst_n), .expire(expire), .ack_wr(ack_wr), .pend(pend)
    );

    assign irq = pend;
endmodule

// File: rtl/tmr_countdown_chk.sv
module tmr_countdown_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             trig_wr,
    input logic             ack_wr,
    input tmr_state_e       cur_state,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] cur_reload,
    input logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_count <= cur_reload);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != ST_IDLE && tick && !trig_wr && cur_count != '0)
        |=> cur_count == $past(cur_count) - ONE);

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !trig_wr) |=> ($stable(cur_count) && $stable(cur_state)));

    // R5
    oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_ONESHOT && tick && !trig_wr && cur_count == '0)
        |=> (cur_state == ST_IDLE && irq));

    // R6
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_PERIODIC && tick && !trig_wr && cur_count == '0)
        |=> (cur_state == ST_PERIODIC && cur_count == $past(cur_reload) && irq));

    // R11
    expire_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && tick && !trig_wr && cur_state != ST_IDLE && cur_count == '0)
        |=> irq);

    // R12
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq);
endmodule

bind tmr_countdown tmr_countdown_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_wr(trig_wr), .ack_wr(ack_wr),
    .cur_state(cur_state), .cur_count(cur_count), .cur_reload(cur_reload),
    .irq(irq)
);

// File: tb/sim_tmr_countdown.sv
module sim_tmr_countdown;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    localparam logic [31:0] CLR = 32'h4000_0000;

    tmr_countdown u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #4 clk = ~clk;

    // behavioural reference
    bit          m_en, m_per, m_pend;
    logic [28:0] m_rel, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_per = 0; m_pend = 0; m_rel = 0; m_cnt = 0;
        end else begin
            bit fired;
            fired = 0;
            if (reg_we && reg_addr == 4'h0) begin
                m_rel = reg_wdata[28:0];
                m_cnt = reg_wdata[28:0];
                m_en  = reg_wdata[31];
                m_per = reg_wdata[31] && reg_wdata[30];
            end else if (tick && m_en) begin
                if (m_cnt == 0) begin
                    fired = 1;
                    if (m_per) m_cnt = m_rel;
                    else begin m_en = 0; m_per = 0; end
                end else m_cnt = m_cnt - 1;
            end
            if (fired) m_pend = 1;
            else if (reg_we && reg_addr == 4'h4 && reg_wdata[30]) m_pend = 0;
        end
    end

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        if (a == 4'h0) return {m_en, m_per, 1'b0, m_rel};
        if (a == 4'h4) return {1'b0, m_pend, 1'b0, m_cnt};
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // apply inputs for one edge, then compare against the model
    task automatic step(input bit t, input bit we, input logic [3:0] a,
                        input logic [31:0] d);
        tick = t; reg_we = we; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        chk(irq == m_pend, "R12 irq level", {31'b0, irq}, {31'b0, m_pend});
        chk(reg_rdata == model_rd(a), (a == 4'h0) ? "R2 trigger readback" : "R9 count readback",
            reg_rdata, model_rd(a));
    endtask

    task automatic rd(input logic [3:0] a);
        step(1'b0, 1'b0, a, 32'h0);
    endtask

    // ticks every `gap` cycles until irq rises; returns ticks used
    task automatic ticks_to_irq(input int gap, output int n);
        n = 0;
        while (!irq && n < 1000) begin
            for (int g = 1; g < gap; g++) step(1'b0, 1'b0, 4'h4, 32'h0);
            step(1'b1, 1'b0, 4'h4, 32'h0);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'h0); chk(reg_rdata == 0, "R1 trigger after reset", reg_rdata, 0);
        rd(4'h4); chk(reg_rdata == 0 && !irq, "R1 count after reset", reg_rdata, 0);

        // R2/R4/R5: one-shot, reload 3, tick every cycle
        step(1'b0, 1'b1, 4'h0, 32'h8000_0003);
        chk(reg_rdata == 32'h8000_0003, "R2 armed readback", reg_rdata, 32'h8000_0003);
        ticks_to_irq(1, n);
        chk(n == 4, "R4 oneshot N+1 ticks", n, 4);
        rd(4'h0); chk(reg_rdata[31] == 1'b0, "R5 enable self-clears", reg_rdata, 32'h3);
        step(1'b1, 1'b0, 4'h4, 32'h0);
        step(1'b1, 1'b0, 4'h4, 32'h0);
        chk(reg_rdata == CLR, "R5 count stays 0, R9 pend bit", reg_rdata, CLR);

        // R10: clear needs bit 30
        step(1'b0, 1'b1, 4'h4, 32'hBFFF_FFFF);
        chk(irq == 1'b1, "R10 write without bit30 ignored", irq, 1);
        step(1'b0, 1'b1, 4'h4, CLR);
        chk(irq == 1'b0, "R10 clear", irq, 0);

        // R3: hold without tick, decrement with sparse ticks
        step(1'b0, 1'b1, 4'h0, 32'h8000_0005);
        repeat (3) rd(4'h4);
        chk(reg_rdata == 32'd5, "R3 hold without tick", reg_rdata, 5);
        ticks_to_irq(3, n);
        chk(n == 6, "R4 sparse ticks N+1", n, 6);
        step(1'b0, 1'b1, 4'h4, CLR);

        // R6: periodic, reload 2
        step(1'b0, 1'b1, 4'h0, 32'hC000_0002);
        ticks_to_irq(2, n);
        chk(n == 3, "R6 first period", n, 3);
        rd(4'h0); chk(reg_rdata == 32'hC000_0002, "R6 still running", reg_rdata, 32'hC000_0002);
        step(1'b0, 1'b1, 4'h4, CLR);
        ticks_to_irq(1, n);
        chk(n == 3, "R6 second period", n, 3);
        step(1'b0, 1'b1, 4'h4, CLR);

        // R7: stop
        step(1'b0, 1'b1, 4'h0, 32'h0);
        rd(4'h0); chk(reg_rdata == 0, "R7 stopped readback", reg_rdata, 0);
        repeat (5) step(1'b1, 1'b0, 4'h4, 32'h0);
        chk(!irq && reg_rdata == 0, "R7 no event after stop", reg_rdata, 0);

        // R8/R13: restart with simultaneous tick
        step(1'b0, 1'b1, 4'h0, 32'h8000_0014);
        repeat (5) step(1'b1, 1'b0, 4'h4, 32'h0);
        chk(reg_rdata == 32'd15, "R3 five ticks", reg_rdata, 15);
        step(1'b1, 1'b1, 4'h0, 32'h8000_0004);
        rd(4'h4); chk(reg_rdata == 32'd4, "R13 write beats tick", reg_rdata, 4);
        ticks_to_irq(1, n);
        chk(n == 5, "R8 restart count", n, 5);
        step(1'b0, 1'b1, 4'h4, CLR);

        // R13: reload 0 gives one-tick event
        step(1'b0, 1'b1, 4'h0, 32'h8000_0000);
        ticks_to_irq(1, n);
        chk(n == 1, "R13 reload zero", n, 1);
        step(1'b0, 1'b1, 4'h4, CLR);

        // R11: expiry and clear together
        step(1'b0, 1'b1, 4'h0, 32'hC000_0000);
        step(1'b1, 1'b1, 4'h4, CLR);
        chk(irq == 1'b1, "R11 expiry beats clear", irq, 1);
        step(1'b0, 1'b1, 4'h0, 32'h0);
        step(1'b0, 1'b1, 4'h4, CLR);

        // random mix compared every cycle
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 4)
                step($urandom_range(0, 1) == 1, 1'b1, 4'h0,
                     {$urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1'b0,
                      29'($urandom_range(0, 9))});
            else if (r < 10)
                step($urandom_range(0, 1) == 1, 1'b1, 4'h4, CLR);
            else
                step($urandom_range(0, 2) == 0, 1'b0,
                     ($urandom_range(0, 1) == 1) ? 4'h4 : 4'h0, 32'h0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule